// File: doc/BRIEF.md
# Post-Reset Configuration Byte Loader

After reset is released, this block fetches a short run of configuration bytes from memory and stores them in a bank of configuration registers. These are the first memory reads the device makes. Each stored byte is exported raw so that downstream logic can decode bus width, bus-control and bus-timing modes, wait states, powerdown enable, watchdog control and the addressing mode. When the last enabled byte has been captured, a done flag rises. This flag releases the rest of the system.

The fetch uses a read request channel with a valid/ready handshake and a one-beat response. A static strap chooses the source region: an external memory window or an internal nonvolatile window. A second static input says whether the optional third byte is fetched. Software-style writes reach the bank through a write port. They are honoured only while loading is in progress. Once done is high, the bank is locked until the next reset.

Top module: `cfg_boot_loader`

## Requirements
- R1: On the first rising clock edge after rst_n is released, req_valid goes high with req_addr at the base address. The base is 0xF2018 when strap_internal is 0 and 0xFF2018 when it is 1.
- R2: Byte N is requested from base + 2*N, in the order byte 0, byte 1, then byte 2.
- R3: While req_valid is high and req_ready is low, req_valid stays high and req_addr stays unchanged on the next cycle. No new request is made until the response for the current one has arrived.
- R4: The rsp_data value accepted with rsp_valid for byte N appears in cfg_bytes[8N+7:8N] on the following cycle.
- R5: When opt_byte_en is 1, exactly three requests are made. When it is 0, exactly two are made, and byte 2 keeps its reset value 0xFF unless the write port changed it before done.
- R6: cfg_done is 0 from reset until the last enabled byte is captured. It becomes 1 in the same cycle that byte appears on cfg_bytes, and stays 1 until reset.
- R7: Once cfg_done is 1, req_valid stays 0.
- R8: Once cfg_done is 1, wr_en has no effect: cfg_bytes does not change.
- R9: During reset, cfg_done is 0, req_valid is 0 and every configuration byte is 0xFF.
- R10: Before cfg_done, a write with wr_en=1 stores wr_data into byte wr_sel on the next cycle. A fetch capture to the same byte in the same cycle takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_internal | input | 1 | Source select: 0 external window, 1 internal nonvolatile window |
| opt_byte_en | input | 1 | Fetch the optional third byte |
| req_valid | output | 1 | Read request valid |
| req_ready | input | 1 | Read request accepted |
| req_addr | output | 24 | Byte address of the read |
| rsp_valid | input | 1 | Read data valid |
| rsp_data | input | 8 | Read data |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register index for a write |
| wr_data | input | 8 | Register write data |
| cfg_bytes | output | 24 | Configuration bytes, byte N in bits 8N+7:8N |
| cfg_done | output | 1 | Loading complete; bank locked |

## Verification
A wrong index in the sequencer shows up at once on req_addr, at the handshake where the stray address is accepted. It also puts the fetched byte in the wrong lane of cfg_bytes one cycle later. A wrong state transition shows as an extra or missing request, or as done rising early or never. The scoreboard catches an extra request at that same handshake and a missing one when done rises. A broken lock shows only when a write is attempted after done, so the bench writes every index in that window and compares the bank one cycle later.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;
   typedef enum logic [1:0] {
      SQ_START = 2'd0,
      SQ_FETCH = 2'd1,
      SQ_WAIT  = 2'd2,
      SQ_DONE  = 2'd3
   } seq_state_t;

   function automatic int unsigned idx_bits(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/cfgl_addr_gen.sv
module cfgl_addr_gen #(
   parameter int unsigned ADDR_W      = 24,
   parameter int unsigned IDX_W       = 2,
   parameter int unsigned STRIDE_LOG2 = 1,
   parameter logic [ADDR_W-1:0] EXT_BASE = 24'h0F2018,
   parameter logic [ADDR_W-1:0] INT_BASE = 24'hFF2018
) (
   input  logic              sel_internal,
   input  logic [IDX_W-1:0]  idx,
   output logic [ADDR_W-1:0] addr
);
   logic [ADDR_W-1:0] base;
   logic [ADDR_W-1:0] offset;

   generate
      if (EXT_BASE == INT_BASE) begin : g_one_base
         logic unused_sel;
         assign unused_sel = sel_internal;
         assign base = EXT_BASE;
      end else begin : g_two_base
         assign base = sel_internal ? INT_BASE : EXT_BASE;
      end
   endgenerate

   assign offset = ADDR_W'(idx) << STRIDE_LOG2;
   assign addr   = base + offset;
endmodule

// File: rtl/cfgl_seq.sv
module cfgl_seq
   import cfgl_pkg::*;
#(
   parameter int unsigned NUM_CFG = 3,
   parameter int unsigned IDX_W   = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             opt_en,
   input  logic             req_ready,
   input  logic             rsp_valid,
   output logic             req_valid,
   output logic [IDX_W-1:0] idx,
   output logic             cap_en,
   output logic             done
);
   localparam logic [IDX_W-1:0] LAST_FULL = IDX_W'(NUM_CFG - 1);
   localparam logic [IDX_W-1:0] LAST_BASE = IDX_W'(NUM_CFG - 2);

   seq_state_t       state_q, state_d;
   logic [IDX_W-1:0] idx_q, idx_d;
   logic [IDX_W-1:0] last_idx;

   assign last_idx = opt_en ? LAST_FULL : LAST_BASE;

   always_comb begin
      state_d = state_q;
      idx_d   = idx_q;
      unique case (state_q)
         SQ_START: state_d = SQ_FETCH;
         SQ_FETCH: if (req_ready) state_d = SQ_WAIT;
         SQ_WAIT: begin
            if (rsp_valid) begin
               if (idx_q == last_idx) begin
                  state_d = SQ_DONE;
               end else begin
                  idx_d   = idx_q + IDX_W'(1);
                  state_d = SQ_FETCH;
               end
            end
         end
         default: state_d = SQ_DONE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_START;
         idx_q   <= '0;
      end else begin
         state_q <= state_d;
         idx_q   <= idx_d;
      end
   end

   assign req_valid = (state_q == SQ_FETCH);
   assign cap_en    = (state_q == SQ_WAIT) && rsp_valid;
   assign done      = (state_q == SQ_DONE);
   assign idx       = idx_q;

   assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready) |=> (req_valid && $stable(idx)));

   assert_done_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> done);

   assert_done_after_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(cap_en));

   assert_no_req_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !req_valid);
endmodule

// File: rtl/cfgl_reg_bank.sv
module cfgl_reg_bank #(
   parameter int unsigned NUM_CFG = 3,
   parameter int unsigned DATA_W  = 8,
   parameter int unsigned IDX_W   = 2,
   parameter logic [NUM_CFG*DATA_W-1:0] RST_VALS = '1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        lock,
   input  logic                        cap_en,
   input  logic [IDX_W-1:0]            cap_idx,
   input  logic [DATA_W-1:0]           cap_data,
   input  logic                        wr_en,
   input  logic [IDX_W-1:0]            wr_sel,
   input  logic [DATA_W-1:0]           wr_data,
   output logic [NUM_CFG*DATA_W-1:0]   cfg_flat
);
   generate
      for (genvar g = 0; g < NUM_CFG; g++) begin : g_reg
         localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);
         logic [DATA_W-1:0] r_q;
         logic              hit_cap, hit_wr;

         assign hit_cap = cap_en && (cap_idx == MY_IDX);
         assign hit_wr  = wr_en && !lock && (wr_sel == MY_IDX);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       r_q <= RST_VALS[g*DATA_W +: DATA_W];
            else if (hit_cap) r_q <= cap_data;
            else if (hit_wr)  r_q <= wr_data;
         end

         assign cfg_flat[g*DATA_W +: DATA_W] = r_q;

         assert_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (cap_en && cap_idx == MY_IDX) |=> (cfg_flat[g*DATA_W +: DATA_W] == $past(cap_data)));
      end
   endgenerate
endmodule

// File: rtl/cfg_boot_loader.sv
module cfg_boot_loader #(
   parameter int unsigned ADDR_W      = 24,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned NUM_CFG     = 3,
   parameter int unsigned STRIDE_LOG2 = 1,
   parameter logic [ADDR_W-1:0] EXT_BASE = 24'h0F2018,
   parameter logic [ADDR_W-1:0] INT_BASE = 24'hFF2018,
   parameter logic [NUM_CFG*DATA_W-1:0] RST_VALS = '1,
   localparam int unsigned IDX_W = cfgl_pkg::idx_bits(NUM_CFG)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      strap_internal,
   input  logic                      opt_byte_en,
   output logic                      req_valid,
   input  logic                      req_ready,
   output logic [ADDR_W-1:0]         req_addr,
   input  logic                      rsp_valid,
   input  logic [DATA_W-1:0]         rsp_data,
   input  logic                      wr_en,
   input  logic [IDX_W-1:0]          wr_sel,
   input  logic [DATA_W-1:0]         wr_data,
   output logic [NUM_CFG*DATA_W-1:0] cfg_bytes,
   output logic                      cfg_done
);
   generate
      if (NUM_CFG < 2) begin : g_bad_count
         $error("NUM_CFG must be at least 2");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("DATA_W must be positive");
      end
      if (ADDR_W < STRIDE_LOG2 + IDX_W) begin : g_bad_addr
         $error("ADDR_W too narrow for the fetch offsets");
      end
   endgenerate

   logic [IDX_W-1:0] idx;
   logic             cap_en;

   cfgl_seq #(.NUM_CFG(NUM_CFG), .IDX_W(IDX_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .opt_en(opt_byte_en),
      .req_ready(req_ready), .rsp_valid(rsp_valid),
      .req_valid(req_valid), .idx(idx), .cap_en(cap_en), .done(cfg_done)
   );

   cfgl_addr_gen #(
      .ADDR_W(ADDR_W), .IDX_W(IDX_W), .STRIDE_LOG2(STRIDE_LOG2),
      .EXT_BASE(EXT_BASE), .INT_BASE(INT_BASE)
   ) u_addr (
      .sel_internal(strap_internal), .idx(idx), .addr(req_addr)
   );

   cfgl_reg_bank #(
      .NUM_CFG(NUM_CFG), .DATA_W(DATA_W), .IDX_W(IDX_W), .RST_VALS(RST_VALS)
   ) u_bank (
      .clk(clk), .rst_n(rst_n), .lock(cfg_done),
      .cap_en(cap_en), .cap_idx(idx), .cap_data(rsp_data),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .cfg_flat(cfg_bytes)
   );

   assert_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_done |=> $stable(cfg_bytes));

   assert_addr_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready) |=> $stable(req_addr));
endmodule

// File: tb/sim_cfg_boot_loader.sv
module sim_cfg_boot_loader;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        strap_internal = 1'b0;
   logic        opt_byte_en = 1'b1;
   logic        req_valid;
   logic        req_ready = 1'b0;
   logic [23:0] req_addr;
   logic        rsp_valid = 1'b0;
   logic [7:0]  rsp_data = 8'h00;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_sel = 2'd0;
   logic [7:0]  wr_data = 8'h00;
   logic [23:0] cfg_bytes;
   logic        cfg_done;

   int tests = 0;
   int fails = 0;
   logic [23:0] exp_q[$];
   int          hs_count = 0;
   int          served = 0;
   logic [23:0] pend_addr = '0;
   int          rdy_dly = 0, rsp_dly = 0, await_c = 0, rwait_c = 0;
   logic        prev_wait = 1'b0;
   logic [23:0] prev_addr = '0;

   always #4 clk = ~clk;

   cfg_boot_loader u0 (
      .clk(clk), .rst_n(rst_n), .strap_internal(strap_internal),
      .opt_byte_en(opt_byte_en), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .cfg_bytes(cfg_bytes), .cfg_done(cfg_done)
   );

   function automatic logic [7:0] mem_byte(input logic [23:0] a);
      return a[7:0] + a[23:16];
   endfunction

   task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // monitor: scoreboard pop on each accepted request, plus hold check
   always @(posedge clk) begin
      if (rst_n) begin
         if (prev_wait)
            check(req_valid && req_addr == prev_addr, "R3 request held", {7'd0, req_valid, req_addr}, {8'd1, prev_addr});
         if (req_valid && req_ready) begin
            if (exp_q.size() == 0) check(1'b0, "R7 extra request", {8'd0, req_addr}, 32'd0);
            else begin
               logic [23:0] e;
               e = exp_q.pop_front();
               check(req_addr == e, "R2 request address", {8'd0, req_addr}, {8'd0, e});
            end
            pend_addr = req_addr;
            hs_count++;
         end
         prev_wait = req_valid && !req_ready;
         prev_addr = req_addr;
      end else prev_wait = 1'b0;
   end

   // memory responder
   initial begin
      forever begin
         @(negedge clk);
         req_ready = 1'b0;
         rsp_valid = 1'b0;
         if (rst_n) begin
            if (served < hs_count) begin
               if (rwait_c == 0) begin
                  rsp_valid = 1'b1;
                  rsp_data  = mem_byte(pend_addr);
                  served++;
                  rwait_c   = rsp_dly;
               end else rwait_c--;
            end else if (req_valid) begin
               if (await_c == 0) begin
                  req_ready = 1'b1;
                  await_c   = rdy_dly;
               end else await_c--;
            end
         end
      end
   end

   task automatic run_case(input bit internal, input bit opt, input int rd, input int sd, input bit pre_wr);
      logic [23:0] base;
      logic [23:0] exp_cfg;
      int n;
      base = internal ? 24'hFF2018 : 24'h0F2018;
      n = opt ? 3 : 2;
      @(negedge clk);
      rst_n = 1'b0;
      strap_internal = internal;
      opt_byte_en = opt;
      rdy_dly = rd; rsp_dly = sd; await_c = rd; rwait_c = sd;
      hs_count = 0; served = 0;
      exp_q.delete();
      exp_cfg = 24'hFFFFFF;
      for (int i = 0; i < n; i++) begin
         exp_q.push_back(base + 24'(2 * i));
         exp_cfg[i*8 +: 8] = mem_byte(base + 24'(2 * i));
      end
      if (pre_wr && !opt) exp_cfg[23:16] = 8'h5A;
      repeat (3) @(negedge clk);
      check(!cfg_done, "R9 done in reset", {31'd0, cfg_done}, 32'd0);
      check(!req_valid, "R9 req in reset", {31'd0, req_valid}, 32'd0);
      check(cfg_bytes == 24'hFFFFFF, "R9 reset bytes", {8'd0, cfg_bytes}, 32'h00FFFFFF);
      rst_n = 1'b1;
      if (pre_wr) begin
         wr_en = 1'b1; wr_sel = 2'd2; wr_data = 8'h5A;
      end
      @(negedge clk);
      wr_en = 1'b0;
      check(req_valid && req_addr == base, "R1 first request", {7'd0, req_valid, req_addr}, {8'd1, base});
      if (pre_wr)
         check(cfg_bytes[23:16] == 8'h5A, "R10 write before done", {24'd0, cfg_bytes[23:16]}, 32'h5A);
      for (int t = 0; t < 200 && !cfg_done; t++) begin
         check(!cfg_done, "R6 done low while loading", {31'd0, cfg_done}, 32'd0);
         @(negedge clk);
      end
      check(cfg_done, "R6 done raised", {31'd0, cfg_done}, 32'd1);
      check(exp_q.size() == 0, "R5 request count", exp_q.size(), 32'd0);
      check(hs_count == n, "R5 handshakes", hs_count, n);
      check(cfg_bytes == exp_cfg, "R4 captured bytes", {8'd0, cfg_bytes}, {8'd0, exp_cfg});
      for (int k = 0; k < 4; k++) begin
         wr_en = 1'b1; wr_sel = 2'(k); wr_data = 8'h00;
         @(negedge clk);
         check(!req_valid, "R7 no request after done", {31'd0, req_valid}, 32'd0);
         check(cfg_done, "R6 done stays high", {31'd0, cfg_done}, 32'd1);
         check(cfg_bytes == exp_cfg, "R8 locked bytes", {8'd0, cfg_bytes}, {8'd0, exp_cfg});
      end
      wr_en = 1'b0;
   endtask

   initial begin
      #(8 * 100000);
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      run_case(1'b0, 1'b1, 0, 0, 1'b0);
      run_case(1'b0, 1'b0, 2, 1, 1'b1);
      run_case(1'b1, 1'b1, 1, 3, 1'b0);
      run_case(1'b1, 1'b0, 0, 2, 1'b0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule